// File: doc/BRIEF.md
# SPI Host Controller with Paired Byte Queues

This block is a polled serial-peripheral-interface host. Software talks to it through a small register window of four words. One of those words is a data port that leads to two separate byte queues. Storing to the data port appends a byte to the outgoing queue. Loading from the same port takes the oldest byte from the incoming queue. A one-byte shift engine drives the serial clock and the outgoing data line. It samples the incoming data line and fills the incoming queue, one byte for every byte it sends. To read N bytes from a device, software therefore queues N bytes, which may be dummy values, and then collects the N replies.

The engine is a four-state machine: `ST_IDLE`, `ST_SETUP` (clock low, bit presented), `ST_HIGH` (clock high, bit sampled) and `ST_DONE` (reply byte stored). Its transitions are:

- **start**: from idle to setup, when the run bit is set, the outgoing queue holds data and the incoming queue has room.
- **rise**: from setup to high, after one half period.
- **fall**: from high back to setup, after one half period, for bits before the last.
- **finish**: from high to done, after the last bit.
- **retire**: from done back to idle, in one cycle.

A control word holds the run bit, the device-select bit and the loopback bit, and offers a self-clearing flush bit. A divider word sets the half period of the serial clock. A status word reports the queue levels and the busy state.

Top module: `spi_host_ctrl`

Register window. The bus address selects the word:

| Address | Word | Fields |
|---|---|---|
| 0 | control | bit 0 run, bit 1 device select, bit 2 loopback, bit 3 flush (write only, reads as 0) |
| 1 | status (read only) | bit 0 outgoing full, bit 1 outgoing empty, bit 2 incoming empty, bit 3 incoming has data, bit 4 busy, bit 5 incoming full |
| 2 | data | a write pushes to the outgoing queue, a read pops from the incoming queue |
| 3 | divider | bits 15:0, the half period in system clocks |

## Requirements
- R1: After reset, both chip-enable outputs are high, the serial clock and the serial data output are low, and the status word reads 0x06 (both queues empty, not busy).
- R2: A write to address 2 appends its low byte to the outgoing queue, which holds 64 bytes. While that queue is full (status bit 0), a further write there is dropped.
- R3: A read of address 2 returns the oldest incoming byte and removes it. When the incoming queue is empty, the read returns 0 and the status word stays unchanged.
- R4: While the run bit (control bit 0) is clear, no byte starts: the serial clock stays low and queued outgoing bytes stay queued.
- R5: Bytes go out most significant bit first. The serial clock idles low. The data output changes only while the clock is low and holds steady at each rising clock edge.
- R6: Each byte sent stores exactly one byte into the incoming queue. That byte is made of the 8 values of the serial input sampled at the rising clock edges, first sample most significant, and replies keep their order.
- R7: Control bit 1 selects the device: 0 drives chip-enable 0 low, 1 drives chip-enable 1 low. The two are never low together.
- R8: The selected chip enable stays low while the run bit is set. If the run bit is cleared in the middle of a byte, the chip enable stays low until that byte has finished, then goes high.
- R9: The serial clock stays high for, and low for, the divider value (address 3) in system clocks. A divider of 0 acts as 1.
- R10: With loopback (control bit 2) set, the serial output feeds the receiver in place of the serial input pin, so each incoming byte equals the byte sent.
- R11: Writing control with bit 3 set empties both queues at that clock edge, so the next status read shows both empty.
- R12: Status bit 4 is high from the start of a byte until it has been stored. Status bit 3 is the inverse of status bit 2.
- R13: When the incoming queue is full (64 bytes, status bit 5), no new byte starts. Outgoing bytes wait until software pops an incoming byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register word select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; pops on data reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_ce_n | output | 2 | Active-low device enables |

## Verification
The checker assumes that the bus never issues a read and a write in the same cycle. It also assumes that the divider and the device-select bit change only while the engine is idle, and that the serial input is steady around each rising clock edge. The bench meets these assumptions as follows. Each access task drives exactly one strobe for one cycle. The divider and the device select are changed only after a status poll has shown the engine idle. The bench's device model changes its output only after a falling serial-clock edge.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HIGH  = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam logic [1:0] ADR_DIV  = 2'd3;

    localparam int CTL_RUN  = 0;
    localparam int CTL_SEL  = 1;
    localparam int CTL_LOOP = 2;
    localparam int CTL_CLR  = 3;

    localparam int STS_TXFULL  = 0;
    localparam int STS_TXEMPTY = 1;
    localparam int STS_RXEMPTY = 2;
    localparam int STS_RXAVAIL = 3;
    localparam int STS_BUSY    = 4;
    localparam int STS_RXFULL  = 5;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rx_head,
    output logic              run,
    output logic              cs_sel,
    output logic              loop_en,
    output logic              fifo_clr,
    output logic [DIV_W-1:0]  div_val,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_pop
);
    logic             run_q, sel_q, loop_q;
    logic [DIV_W-1:0] div_q;
    logic             wr_ctrl, wr_div;

    assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_div   = bus_wr && (bus_addr == ADR_DIV);
    assign fifo_clr = wr_ctrl && bus_wdata[CTL_CLR];
    assign tx_push  = bus_wr && (bus_addr == ADR_DATA);
    assign tx_byte  = bus_wdata[BYTE_W-1:0];
    assign rx_pop   = bus_rd && (bus_addr == ADR_DATA);
    assign run      = run_q;
    assign cs_sel   = sel_q;
    assign loop_en  = loop_q;
    assign div_val  = div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            sel_q  <= 1'b0;
            loop_q <= 1'b0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= bus_wdata[CTL_RUN];
                sel_q  <= bus_wdata[CTL_SEL];
                loop_q <= bus_wdata[CTL_LOOP];
            end
            if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[CTL_RUN]  = run_q;
                bus_rdata[CTL_SEL]  = sel_q;
                bus_rdata[CTL_LOOP] = loop_q;
            end
            ADR_STAT: begin
                bus_rdata[STS_TXFULL]  = tx_full;
                bus_rdata[STS_TXEMPTY] = tx_empty;
                bus_rdata[STS_RXEMPTY] = rx_empty;
                bus_rdata[STS_RXAVAIL] = !rx_empty;
                bus_rdata[STS_BUSY]    = busy;
                bus_rdata[STS_RXFULL]  = rx_full;
            end
            ADR_DATA: begin
                if (!rx_empty) bus_rdata[BYTE_W-1:0] = rx_head;
            end
            ADR_DIV: bus_rdata[DIV_W-1:0] = div_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_host_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int NCE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cs_sel,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso_in,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [NCE-1:0]    ce_n
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    eng_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, half;
    logic [BIT_W-1:0] bit_q;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic             cs_q, tick, start, ce_act, cs_eff;

    assign half  = (div_val == '0) ? DIV_W'(1) : div_val;
    assign tick  = (cnt_q == half - 1'b1);
    assign start = (state_q == ST_IDLE) && (state_d == ST_SETUP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, rise, fall, finish, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run && !tx_empty && !rx_full) state_d = ST_SETUP;
            ST_SETUP: if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = (bit_q == LAST_BIT) ? ST_DONE : ST_SETUP;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath: half-period counter, shifters, bit count, latched select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
            cs_q  <= 1'b0;
        end else begin
            if (state_q != state_d)
                cnt_q <= '0;
            else if (state_q == ST_SETUP || state_q == ST_HIGH)
                cnt_q <= cnt_q + 1'b1;
            if (start) begin
                tx_sh <= tx_byte;
                bit_q <= '0;
                cs_q  <= cs_sel;
            end
            if (state_q == ST_SETUP && tick)
                rx_sh <= {rx_sh[BYTE_W-2:0], miso_in};
            if (state_q == ST_HIGH && tick && bit_q != LAST_BIT) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        sclk    = (state_q == ST_HIGH);
        mosi    = busy ? tx_sh[BYTE_W-1] : 1'b0;
        tx_pop  = start;
        rx_push = (state_q == ST_DONE);
        rx_byte = rx_sh;
        ce_act  = run || busy;
        cs_eff  = busy ? cs_q : cs_sel;
    end

    for (genvar g = 0; g < NCE; g++) begin : g_ce
        assign ce_n[g] = !(ce_act && (int'(cs_eff) == g));
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int Q_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [1:0]        spi_ce_n
);
    logic              run, cs_sel, loop_en, fifo_clr, busy;
    logic [DIV_W-1:0]  div_val;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [BYTE_W-1:0] tx_wbyte, tx_head, rx_wbyte, rx_head;
    logic              miso_in;

    assign miso_in = loop_en ? spi_mosi : spi_miso;

    spi_host_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_empty(rx_empty), .busy(busy), .rx_head(rx_head), .run(run),
        .cs_sel(cs_sel), .loop_en(loop_en), .fifo_clr(fifo_clr),
        .div_val(div_val), .tx_push(tx_push), .tx_byte(tx_wbyte), .rx_pop(rx_pop)
    );

    spi_byte_fifo #(.DW(BYTE_W), .DEPTH(Q_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(tx_push), .pop(tx_pop),
        .wdata(tx_wbyte), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.DW(BYTE_W), .DEPTH(Q_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(rx_push), .pop(rx_pop),
        .wdata(rx_wbyte), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .NCE(2)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .cs_sel(cs_sel), .div_val(div_val),
        .tx_empty(tx_empty), .rx_full(rx_full), .tx_byte(tx_head),
        .miso_in(miso_in), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_byte(rx_wbyte), .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi),
        .ce_n(spi_ce_n)
    );
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ce_n,
    input logic       sclk,
    input logic       mosi,
    input logic       run,
    input logic       busy,
    input logic       fifo_clr,
    input logic       tx_empty,
    input logic       tx_full,
    input logic       rx_empty,
    input logic       rx_full
);
    // R7
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_n) <= 1);

    // R8
    ce_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ce_n != 2'b11));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !busy) |=> !busy);

    // R4
    idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R5
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (tx_empty && rx_empty));

    // R13
    rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !busy) |=> !busy);

    // R2
    tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));
endmodule

bind spi_host_ctrl spi_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(spi_ce_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .run(run), .busy(busy), .fifo_clr(fifo_clr), .tx_empty(tx_empty),
    .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full)
);

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [1:0]  spi_ce_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spi_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ce_n(spi_ce_n)
    );

    // device model: shifts out a reply on falling edges, captures on rising edges
    function automatic logic [7:0] reply(input int k);
        return 8'h3C ^ 8'(k * 41);
    endfunction

    logic [7:0] dev_sh = 8'h3C;
    logic [7:0] dev_cap = '0;
    logic [7:0] dev_got [8];
    int         dev_bits = 0;
    int         dev_nb = 0;
    logic       prev_sclk = 1'b0;
    logic       seen_ce0 = 1'b0, seen_ce1 = 1'b0, seen_sclk = 1'b0;
    assign spi_miso = dev_sh[7];

    always @(negedge clk) begin
        if (!spi_ce_n[0]) seen_ce0 = 1'b1;
        if (!spi_ce_n[1]) seen_ce1 = 1'b1;
        if (spi_sclk)     seen_sclk = 1'b1;
        if (&spi_ce_n) begin
            dev_bits = 0;
            dev_nb   = 0;
            dev_sh   = reply(0);
        end else if (spi_sclk && !prev_sclk) begin
            dev_cap = {dev_cap[6:0], spi_mosi};
            if (dev_bits == 7) begin
                if (dev_nb < 8) dev_got[dev_nb] = dev_cap;
                dev_nb   = dev_nb + 1;
                dev_bits = 0;
            end else begin
                dev_bits = dev_bits + 1;
            end
        end else if (!spi_sclk && prev_sclk) begin
            if (dev_bits == 0) dev_sh = reply(dev_nb);
            else               dev_sh = {dev_sh[6:0], 1'b0};
        end
        prev_sclk = spi_sclk;
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd1, s);
            if (!s[4] && s[1]) return;
        end
        check(1'b0, "R12 idle wait", s, 32'h2);
    endtask

    task automatic t_reset();
        logic [31:0] s;
        check(spi_ce_n == 2'b11, "R1 ce_n", spi_ce_n, 2'b11);
        check(!spi_sclk && !spi_mosi, "R1 sclk/mosi", {spi_sclk, spi_mosi}, 0);
        rd(2'd1, s);
        check(s == 32'h06, "R1 status", s, 32'h06);
    endtask

    task automatic t_fill();
        logic [31:0] s;
        for (int k = 0; k < 65; k++) wr(2'd2, 32'(k));
        rd(2'd1, s);
        check(s[0] == 1'b1, "R2 tx full", s, 32'h1);
        seen_sclk = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        check(!seen_sclk, "R4 no clock while stopped", seen_sclk, 0);
        rd(2'd1, s);
        check(s[0] == 1'b1, "R4 queue kept", s, 32'h1);
    endtask

    task automatic t_loop_stall();
        logic [31:0] s, d;
        int i;
        wr(2'd0, 32'h5);
        i = 0;
        do begin rd(2'd1, s); i++; end while (!(s[5] && !s[4] && s[1]) && i < 5000);
        check(s == 32'h2A, "R13 rx full status", s, 32'h2A);
        wr(2'd2, 32'hEE);
        repeat (80) @(posedge clk);
        rd(2'd1, s);
        check(s[1] == 1'b0 && s[4] == 1'b0, "R13 stalled", s, 32'h28);
        for (int k = 0; k < 64; k++) begin
            rd(2'd2, d);
            check(d == 32'(k), "R10 R3 loopback order", d, k);
        end
        wait_idle();
        rd(2'd2, d);
        check(d == 32'hEE, "R13 resumed, R2 65th dropped", d, 32'hEE);
        rd(2'd1, s);
        rd(2'd2, d);
        check(d == 0, "R3 empty read", d, 0);
        rd(2'd1, d);
        check(d == s && s[2] && !s[3], "R3 R12 empty status", d, s);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_exchange();
        logic [31:0] s, d;
        logic [7:0] pat [4];
        pat[0] = 8'h5A; pat[1] = 8'hC3; pat[2] = 8'h0F; pat[3] = 8'h81;
        wr(2'd3, 32'd2);
        seen_ce0 = 1'b0; seen_ce1 = 1'b0;
        wr(2'd0, 32'h1);
        for (int k = 0; k < 4; k++) wr(2'd2, 32'(pat[k]));
        rd(2'd1, s);
        check(s[4] == 1'b1, "R12 busy", s, 32'h10);
        wait_idle();
        check(dev_nb == 4, "R6 byte count", dev_nb, 4);
        for (int k = 0; k < 4; k++)
            check(dev_got[k] == pat[k], "R5 msb first", dev_got[k], pat[k]);
        for (int k = 0; k < 4; k++) begin
            rd(2'd2, d);
            check(d == 32'(reply(k)), "R6 reply", d, reply(k));
        end
        check(seen_ce0 && !seen_ce1, "R7 select 0", {seen_ce1, seen_ce0}, 2'b01);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_sel1();
        logic [31:0] d;
        seen_ce0 = 1'b0; seen_ce1 = 1'b0;
        wr(2'd0, 32'h3);
        wr(2'd2, 32'h77);
        wait_idle();
        rd(2'd2, d);
        check(d == 32'(reply(0)), "R6 reply on select 1", d, reply(0));
        check(seen_ce1 && !seen_ce0, "R7 select 1", {seen_ce1, seen_ce0}, 2'b10);
        wr(2'd0, 32'h0);
    endtask

    task automatic measure_high(input int exp);
        int n;
        logic [31:0] d;
        wr(2'd2, 32'h99);
        @(posedge spi_sclk);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (spi_sclk && n < 100);
        check(n == exp, "R9 half period", n, exp);
        wait_idle();
        rd(2'd2, d);
    endtask

    task automatic t_divider();
        wr(2'd0, 32'h0);
        wr(2'd3, 32'd3);
        wr(2'd0, 32'h1);
        measure_high(3);
        wr(2'd0, 32'h0);
        wr(2'd3, 32'd0);
        wr(2'd0, 32'h1);
        measure_high(1);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_ce_hold();
        logic [31:0] s, d;
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h42);
        wr(2'd0, 32'h0);
        #1;
        check(spi_ce_n == 2'b10, "R8 held mid byte", spi_ce_n, 2'b10);
        wait_idle();
        #1;
        check(spi_ce_n == 2'b11, "R8 released", spi_ce_n, 2'b11);
        rd(2'd1, s);
        check(s[3] && !s[2], "R12 has data", s, 32'h0A);
        rd(2'd2, d);
    endtask

    task automatic t_flush();
        logic [31:0] s;
        wr(2'd0, 32'h5);
        wr(2'd2, 32'h11);
        wait_idle();
        wr(2'd0, 32'h4);
        wr(2'd2, 32'h22);
        wr(2'd2, 32'h33);
        rd(2'd1, s);
        check(!s[1] && s[3], "R11 before flush", s, 32'h08);
        wr(2'd0, 32'h8);
        rd(2'd1, s);
        check(s == 32'h06, "R11 after flush", s, 32'h06);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_loop_stall();
        t_exchange();
        t_sel1();
        t_divider();
        t_ce_hold();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule